// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block decides which interrupt the processor takes next. It serves a set of maskable sources and one non-maskable source (NMI). Each maskable source has a request flag held inside the block, an enable bit and a two-bit priority field. Two global inputs shape the decision. A master enable gates every maskable source. A priority-mode switch selects one of two behaviours: either nesting by level, or granting eligible requests at once in index order.

The block keeps a stack of the levels currently in service. A grant pushes the granted level onto the stack. A return-from-interrupt pulse pops the most recent entry. A one-cycle take strobe carries the vector index of the winner, and the index `NSRC` marks the NMI. The stack is driven by a small state machine with three states:

- `ST_IDLE`: nothing is in service.
- `ST_NEST`: the stack is partly filled.
- `ST_FULL`: every stack slot is in use.

Its transitions are:

- push from idle: `ST_IDLE` to `ST_NEST`.
- push while nested: `ST_NEST` to `ST_NEST`, or to `ST_FULL` on the last free slot.
- pop from full: `ST_FULL` to `ST_NEST`.
- pop while nested: `ST_NEST` to `ST_NEST`, or to `ST_IDLE` when the last entry leaves.

A pop in `ST_IDLE` and a push in `ST_FULL` change nothing.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A maskable source takes part in arbitration only when its request flag, its enable bit and the master enable are all 1. Otherwise its flag stays set and no take is produced for it.
- R2: With the priority-mode input at 0, an eligible maskable request is granted whatever is in service. Among several such requests, the lowest index wins.
- R3: With the priority-mode input at 1, a source's level comes from its field `irq_pri[2i+1:2i]`: value 0 gives level 0, 1 gives level 1, and both 2 and 3 give level 2 (the highest). The highest level wins, and among equal levels the lowest index wins.
- R4: In priority mode with nothing in service, an eligible request is granted.
- R5: In priority mode with entries in service, a maskable request is granted only when its level is strictly above every level in service. An equal or lower level is held.
- R6: A rising edge on `nmi_in` sets one NMI request. The NMI outranks all maskable sources and is granted in any state except while an NMI is in service. Holding `nmi_in` high yields one grant only.
- R7: A request flag set by `irq_set` in one cycle is visible on `pend` after the next clock edge. A grant raises `take` for exactly one cycle, one edge after the cycle of the decision. `take_idx` then carries the winner's index, or `NSRC` for the NMI. The winner's flag clears on that same edge, and a set arriving on that edge loses to the clear. After reset, `take` and `pend` are 0.
- R8: A `reti` pulse pops the most recent in-service entry. No grant is decided in a cycle with `reti` high. A `reti` with nothing in service changes nothing.
- R9: With `DEPTH` entries in service, no grant is made until a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_set | input | NSRC | Per-source pulse that sets the request flag |
| irq_en | input | NSRC | Per-source enable |
| irq_pri | input | 2*NSRC | Two-bit priority field per source |
| mst_en | input | 1 | Master enable for maskable sources |
| pri_mode | input | 1 | 1 = nesting by level, 0 = immediate grant |
| nmi_in | input | 1 | Non-maskable request, edge-detected |
| reti | input | 1 | Return from interrupt, pops one level |
| take | output | 1 | One-cycle grant strobe |
| take_idx | output | IW | Vector index of the granted source (NSRC = NMI) |
| pend | output | NSRC | Maskable request flags |

## Verification
The bench builds the block with `NSRC` = 8 and `DEPTH` = 4. Under these values, five simultaneous requests in non-priority mode fill the stack and leave one request held, which shows the full-stack behaviour. The NMI index 8 is distinct from every maskable index. Eight sources also leave room for field value 3 to tie with value 2, and for lower and equal levels to wait under a nested level-1 and level-2 pair.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef logic [2:0] svc_code_t;

    localparam svc_code_t CODE_NONE = 3'd0;
    localparam svc_code_t CODE_NMI  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NEST,
        ST_FULL
    } svc_state_e;

    // Field value to in-service code: 0,1,2 -> 1,2,3 and 3 -> 3 (level 2)
    function automatic svc_code_t lvl_code(input logic [1:0] fld);
        return (fld == 2'd3) ? 3'd3 : ({1'b0, fld} + 3'd1);
    endfunction

endpackage

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IW   = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0]   pend,
    input  logic [NSRC-1:0]   irq_en,
    input  logic [2*NSRC-1:0] irq_pri,
    input  logic              mst_en,
    input  logic              pri_mode,
    input  logic              nmi_pend,
    input  svc_code_t         svc_max,
    input  logic              nmi_busy,
    input  logic              can_grant,
    output logic              grant,
    output logic              grant_nmi,
    output logic [IW-1:0]     grant_idx,
    output svc_code_t         grant_code
);

    logic      best_ok;
    svc_code_t best_code;
    svc_code_t best_rank;
    logic [IW-1:0] best_idx;
    svc_code_t code_i;
    svc_code_t rank_i;
    logic      ok_i;
    logic      nmi_ok;

    // Scan downward so that on equal rank the lower index overrides
    always_comb begin
        best_ok   = 1'b0;
        best_code = CODE_NONE;
        best_rank = CODE_NONE;
        best_idx  = '0;
        code_i    = CODE_NONE;
        rank_i    = CODE_NONE;
        ok_i      = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            code_i = lvl_code(irq_pri[2*i +: 2]);
            rank_i = pri_mode ? code_i : 3'd1;
            ok_i   = pend[i] & irq_en[i] & mst_en & (!pri_mode || (code_i > svc_max));
            if (ok_i && (!best_ok || rank_i >= best_rank)) begin
                best_ok   = 1'b1;
                best_code = code_i;
                best_rank = rank_i;
                best_idx  = IW'(i);
            end
        end
    end

    always_comb begin
        nmi_ok     = nmi_pend & !nmi_busy;
        grant      = can_grant & (nmi_ok | best_ok);
        grant_nmi  = can_grant & nmi_ok;
        grant_idx  = nmi_ok ? IW'(NSRC) : best_idx;
        grant_code = nmi_ok ? CODE_NMI : best_code;
    end

endmodule

// File: rtl/nic_svc_stack.sv
module nic_svc_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SPW   = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  svc_code_t push_code,
    input  logic      pop,
    output logic      can_push,
    output svc_code_t svc_max,
    output logic      nmi_busy
);

    svc_state_e     state_q, state_d;
    logic [SPW-1:0] sp_q;
    svc_code_t      stk_q [DEPTH];
    logic           do_pop, do_push;

    assign do_pop  = pop && (state_q != ST_IDLE);
    assign do_push = push && !pop && (state_q != ST_FULL);

    // State register, stack pointer and stack contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sp_q    <= '0;
            for (int k = 0; k < DEPTH; k++) stk_q[k] <= CODE_NONE;
        end else begin
            state_q <= state_d;
            if (do_pop) begin
                sp_q <= sp_q - SPW'(1);
            end else if (do_push) begin
                stk_q[sp_q[AW-1:0]] <= push_code;
                sp_q                <= sp_q + SPW'(1);
            end
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (do_push) state_d = ST_NEST;
            ST_NEST: begin
                if (do_pop)       state_d = (sp_q == SPW'(1)) ? ST_IDLE : ST_NEST;
                else if (do_push) state_d = (sp_q == SPW'(DEPTH - 1)) ? ST_FULL : ST_NEST;
            end
            ST_FULL: if (do_pop) state_d = ST_NEST;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs: room left, highest code in service, NMI in service
    always_comb begin
        can_push = (state_q != ST_FULL);
        svc_max  = CODE_NONE;
        nmi_busy = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (SPW'(k) < sp_q) begin
                if (stk_q[k] > svc_max) svc_max = stk_q[k];
                if (stk_q[k] == CODE_NMI) nmi_busy = 1'b1;
            end
        end
    end

    AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SPW'(DEPTH)); // R9
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> state_q != ST_FULL); // R9
    AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_code == CODE_NMI) |-> !nmi_busy); // R6
    AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state_q != ST_IDLE) |=> sp_q == $past(sp_q) - SPW'(1)); // R8

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int DEPTH = 4,
    parameter int IW    = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_set,
    input  logic [NSRC-1:0]   irq_en,
    input  logic [2*NSRC-1:0] irq_pri,
    input  logic              mst_en,
    input  logic              pri_mode,
    input  logic              nmi_in,
    input  logic              reti,
    output logic              take,
    output logic [IW-1:0]     take_idx,
    output logic [NSRC-1:0]   pend
);

    localparam int SW = $clog2(NSRC);

    logic [NSRC-1:0] pend_q, pend_clr;
    logic            nmi_q, nmi_pend_q;
    logic            take_q;
    logic [IW-1:0]   take_idx_q;

    logic            grant, grant_nmi, can_push;
    logic [IW-1:0]   grant_idx;
    svc_code_t       grant_code, svc_max;
    logic            nmi_busy;

    nic_arbiter #(.NSRC(NSRC), .IW(IW)) u_arb (
        .pend       (pend_q),
        .irq_en     (irq_en),
        .irq_pri    (irq_pri),
        .mst_en     (mst_en),
        .pri_mode   (pri_mode),
        .nmi_pend   (nmi_pend_q),
        .svc_max    (svc_max),
        .nmi_busy   (nmi_busy),
        .can_grant  (can_push & !reti),
        .grant      (grant),
        .grant_nmi  (grant_nmi),
        .grant_idx  (grant_idx),
        .grant_code (grant_code)
    );

    nic_svc_stack #(.DEPTH(DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (grant),
        .push_code (grant_code),
        .pop       (reti),
        .can_push  (can_push),
        .svc_max   (svc_max),
        .nmi_busy  (nmi_busy)
    );

    always_comb begin
        for (int i = 0; i < NSRC; i++)
            pend_clr[i] = grant & !grant_nmi & (grant_idx == IW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= '0;
            nmi_q      <= 1'b0;
            nmi_pend_q <= 1'b0;
            take_q     <= 1'b0;
            take_idx_q <= '0;
        end else begin
            pend_q     <= (pend_q | irq_set) & ~pend_clr;
            nmi_q      <= nmi_in;
            nmi_pend_q <= (nmi_pend_q | (nmi_in & !nmi_q)) & !grant_nmi;
            take_q     <= grant;
            if (grant) take_idx_q <= grant_idx;
        end
    end

    assign take     = take_q;
    assign take_idx = take_idx_q;
    assign pend     = pend_q;

    AST_TAKE_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_idx != IW'(NSRC)) |-> $past(mst_en)); // R1
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_idx < IW'(NSRC)) |-> !pend[take_idx[SW-1:0]]); // R7
    AST_NO_GRANT_ON_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !$past(reti)); // R8
    AST_STRICT_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && pri_mode && !grant_nmi) |-> grant_code > svc_max); // R5

endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;

    localparam int NSRC    = 8;
    localparam int DEPTH   = 4;
    localparam int IW      = $clog2(NSRC + 1);
    localparam int CLK_PER = 10;
    localparam int NONE    = -1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NSRC-1:0]   irq_set, irq_en;
    logic [2*NSRC-1:0] irq_pri;
    logic              mst_en, pri_mode, nmi_in, reti;
    logic              take;
    logic [IW-1:0]     take_idx;
    logic [NSRC-1:0]   pend;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PER / 2) clk = ~clk;

    nest_irq_ctrl #(.NSRC(NSRC), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .irq_en(irq_en),
        .irq_pri(irq_pri), .mst_en(mst_en), .pri_mode(pri_mode),
        .nmi_in(nmi_in), .reti(reti), .take(take), .take_idx(take_idx),
        .pend(pend)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        mode;
        logic [7:0]  en;
        logic [7:0]  set;
        logic [15:0] pri;
        logic [3:0]  expi;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 1'b1, 8'hFF, 8'h06, 16'h0024, 4'd2}, // R3 level 2 beats level 1
        '{4'd3, 1'b1, 8'hFF, 8'h0A, 16'h0044, 4'd1}, // R3 equal level, lower index
        '{4'd3, 1'b1, 8'hFF, 8'h81, 16'hC000, 4'd7}, // R3 field 3 counts as level 2
        '{4'd3, 1'b1, 8'hFF, 8'h84, 16'hC020, 4'd2}, // R3 field 3 ties field 2
        '{4'd2, 1'b0, 8'hFF, 8'h90, 16'h8000, 4'd4}, // R2 index order only
        '{4'd1, 1'b1, 8'hFE, 8'h03, 16'h0002, 4'd1}  // R1 disabled source skipped
    };

    function automatic int tk();
        return take ? int'(take_idx) : NONE;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic pop_all();
        reti = 1'b1;
        repeat (DEPTH + 1) @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic drain();
        mst_en = 1'b1; irq_en = '1; pri_mode = 1'b0; reti = 1'b1;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            reti = take;
            if (!take && pend == '0) break;
        end
        reti = 1'b0;
        pop_all();
    endtask

    task automatic pulse_set(input logic [NSRC-1:0] m);
        @(negedge clk); irq_set = m;
        @(negedge clk); irq_set = '0;
    endtask

    task automatic reti_pulse();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_set = '0; irq_en = '1; irq_pri = '0;
        mst_en = 1'b1; pri_mode = 1'b1; nmi_in = 1'b0; reti = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R7 reset take", tk(), NONE);
        check("R7 reset pend", int'(pend), 0);

        // R8: pop with nothing in service changes nothing
        pop_all();
        @(negedge clk);
        check("R8 empty reti", tk(), NONE);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pri_mode = VECS[v].mode; irq_en = VECS[v].en; irq_pri = VECS[v].pri;
            irq_set = VECS[v].set;
            @(negedge clk); irq_set = '0;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[v].req, v), tk(), int'(VECS[v].expi));
            drain();
        end

        // R1: master enable off holds, then grants
        @(negedge clk);
        mst_en = 1'b0; pri_mode = 1'b1; irq_pri = '0; irq_set = 8'h01;
        @(negedge clk); irq_set = '0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1 master off holds", tk(), NONE);
        end
        check("R1 flag kept", int'(pend[0]), 1);
        mst_en = 1'b1;
        @(negedge clk);
        check("R1 granted after enable", tk(), 0);
        pop_all();

        // R4/R5/R8 nesting: src1 lvl1, src3 lvl1, src5 lvl0, src6 lvl2
        irq_pri = 16'h2044; pri_mode = 1'b1;
        pulse_set(8'h02);
        @(negedge clk);
        check("R4 idle grant", tk(), 1);
        pulse_set(8'h08);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5 equal level held", tk(), NONE);
        end
        pulse_set(8'h20);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5 lower level held", tk(), NONE);
        end
        check("R5 held flags", int'(pend), 'h28);
        pulse_set(8'h40);
        @(negedge clk);
        check("R5 higher level nests", tk(), 6);
        reti_pulse();
        @(negedge clk);
        check("R8 pop leaves level 1, equal still held", tk(), NONE);
        reti_pulse();
        @(negedge clk);
        check("R8 pop to idle grants level 1", tk(), 3);
        @(negedge clk);
        check("R5 level 0 under level 1 held", tk(), NONE);
        reti_pulse();
        @(negedge clk);
        check("R8 pop grants level 0", tk(), 5);
        pop_all();

        // R6: NMI over level 2, one grant per edge, blocked by itself
        irq_pri = 16'h0020;
        pulse_set(8'h04);
        @(negedge clk);
        check("R6 setup level 2", tk(), 2);
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 NMI preempts level 2", tk(), NSRC);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6 held input single grant", tk(), NONE);
        end
        nmi_in = 1'b0;
        @(negedge clk); nmi_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6 NMI blocked by NMI", tk(), NONE);
        end
        reti_pulse();
        @(negedge clk);
        check("R6 second NMI after pop", tk(), NSRC);
        nmi_in = 1'b0;
        pop_all();

        // R9: non-priority mode fills the stack
        pri_mode = 1'b0; irq_pri = '0;
        pulse_set(8'h1F);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            check("R9 fill in index order", tk(), k);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 full stack holds", tk(), NONE);
        end
        check("R9 held flag", int'(pend), 'h10);
        reti_pulse();
        @(negedge clk);
        check("R9 grant after pop", tk(), 4);
        pop_all();

        // R7: set and clear on the same edge resolves to clear
        @(negedge clk); irq_set = 8'h01;
        @(negedge clk);
        @(negedge clk);
        check("R7 take index", tk(), 0);
        check("R7 set loses to clear", int'(pend[0]), 0);
        irq_set = '0;
        @(negedge clk);
        check("R7 strobe one cycle", tk(), NONE);
        pop_all();

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule